// File: doc/BRIEF.md
# Signed Outstanding-Response Tracker

This block keeps one signed counter per in-flight exclusive transaction and tells the controller when every expected response for that transaction has arrived. A slot is opened when a miss starts, which clears its counter to zero, and closed when the transaction retires. Each arriving message that the surrounding logic has already decoded (data, an invalidation ack, or the requester's own exclusive request forwarded back) is presented as an update strobe with the slot index and the signed count the message carries. That count is subtracted from the slot's counter. Because the arithmetic is two's complement, the messages may arrive in any order and the counter may be negative for a while before it settles at zero.

When an update leaves a waiting slot's counter at exactly zero, the slot index is pushed once into a small ordered completion queue. The controller reads the queue head and pops it. The controller is expected to drain this queue before it handles other inputs. While the queue is full, the block raises a stall and does not accept updates. If a subtraction leaves the representable range, the counter saturates and a one-cycle error pulse is raised.

Each slot is a three-state machine. SLOT_IDLE (not allocated) goes to SLOT_WAIT on allocate. SLOT_WAIT goes to SLOT_DONE when an update reaches zero, and this is the cycle that posts the trigger. SLOT_WAIT or SLOT_DONE goes to SLOT_IDLE on free. Any state goes to SLOT_WAIT on allocate, with the counter cleared. In SLOT_DONE, updates still change the counter but post nothing.

Top module: `pend_ctr_top`

## Requirements
- R1: After reset, trig_valid, upd_stall and err_ovf are all 0 and every slot is unallocated.
- R2: An allocate clears the slot's counter to zero and puts it in the waiting state, also when the slot was already in use.
- R3: An accepted update subtracts upd_delta, a CNT_W-bit two's complement value, from the slot's counter.
- R4: When an accepted update leaves a waiting slot's counter at exactly zero, its index is pushed into the completion queue and appears at trig_valid/trig_idx one cycle after the update edge. An update with delta 0 on a freshly allocated slot therefore triggers.
- R5: After a slot has posted its trigger, later zero results for that slot post nothing until it is allocated again.
- R6: Updates to an unallocated or freed slot are ignored. An allocate or free for the same index in the same cycle takes precedence, and the update is dropped.
- R7: The queue is first-in first-out. The head holds until trig_pop is high while trig_valid is high. A pop while empty is ignored. A push and a pop may occur in the same cycle.
- R8: The queue holds Q_DEPTH (default 4) entries. upd_stall is high exactly when it is full, and an update presented while upd_stall is high is not applied.
- R9: A result above 2^(CNT_W-1)-1 saturates to that value, and a result below -2^(CNT_W-1) saturates to that value. err_ovf pulses high for one cycle after such an update.
- R10: Responses may arrive in any order. The counter may pass through negative values, and the trigger fires when the running sum returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Open a slot |
| alloc_idx | input | IDX_W | Slot to open |
| free_valid | input | 1 | Close a slot |
| free_idx | input | IDX_W | Slot to close |
| upd_valid | input | 1 | Response count strobe |
| upd_idx | input | IDX_W | Slot the response belongs to |
| upd_delta | input | CNT_W | Signed count carried by the response |
| upd_stall | output | 1 | Queue full; update not accepted |
| trig_valid | output | 1 | Completion queue not empty |
| trig_idx | output | IDX_W | Slot index at queue head |
| trig_pop | input | 1 | Consume queue head |
| err_ovf | output | 1 | Counter saturated on last update |

## Verification
The counting and trigger logic is driven by seeded random streams of allocates, frees, small signed deltas and pops. A bench model predicts the queue contents, the stall and the error pulse in every cycle. Small deltas make the counters wander through negative values and return to zero often. This separates correct two's complement subtraction from sign or order mistakes, and it catches duplicate or missing triggers. Directed cases cover the following:
- a full queue with an update held off;
- saturation at both range limits, where the follow-up delta shows the clamped value;
- updates that collide with an allocate or free of the same slot;
- updates to unallocated slots.

// File: rtl/pend_ctr_pkg.sv
package pend_ctr_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_t;
endpackage

// File: rtl/pend_slot.sv
module pend_slot
    import pend_ctr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             free_i,
    input  logic             upd_i,
    input  logic [CNT_W-1:0] delta_i,
    output logic             post_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    slot_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   diff;
    logic             wrap;
    logic [CNT_W-1:0] result;
    logic             live;

    // signed subtraction with one guard bit
    always_comb begin
        diff   = {cnt_q[CNT_W-1], cnt_q} - {delta_i[CNT_W-1], delta_i};
        wrap   = diff[CNT_W] ^ diff[CNT_W-1];
        result = wrap ? (diff[CNT_W] ? CNT_MIN : CNT_MAX) : diff[CNT_W-1:0];
        live   = upd_i && !alloc_i && !free_i && (st_q != SLOT_IDLE);
    end

    // next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (alloc_i) begin
            st_d  = SLOT_WAIT;
            cnt_d = '0;
        end else if (free_i) begin
            st_d  = SLOT_IDLE;
        end else begin
            unique case (st_q)
                SLOT_IDLE: ;
                SLOT_WAIT: if (live) begin
                    cnt_d = result;
                    if (result == '0) st_d = SLOT_DONE;
                end
                SLOT_DONE: if (live) cnt_d = result;
                default:   st_d = SLOT_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SLOT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        post_o = live && (st_q == SLOT_WAIT) && (result == '0);
        ovf_o  = live && wrap;
    end
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic [DW-1:0] head_o,
    output logic          full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop, do_push;

    always_comb begin
        valid_o = (cnt_q != '0);
        full_o  = (cnt_q == FULLC);
        head_o  = mem[rd_q];
        do_pop  = pop_i && valid_o;
        do_push = push_i && (!full_o || do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data_i;
    end
endmodule

// File: rtl/pend_ctr_top.sv
module pend_ctr_top
    import pend_ctr_pkg::*;
#(
    parameter int N_TXN   = 8,
    parameter int CNT_W   = 8,
    parameter int Q_DEPTH = 4,
    parameter int IDX_W   = $clog2(N_TXN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             free_valid,
    input  logic [IDX_W-1:0] free_idx,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [CNT_W-1:0] upd_delta,
    output logic             upd_stall,
    output logic             trig_valid,
    output logic [IDX_W-1:0] trig_idx,
    input  logic             trig_pop,
    output logic             err_ovf
);
    logic [N_TXN-1:0] post_v, ovf_v;
    logic             q_full;
    logic             err_q;

    for (genvar g = 0; g < N_TXN; g++) begin : g_slot
        pend_slot #(.CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .alloc_i(alloc_valid && (alloc_idx == IDX_W'(g))),
            .free_i (free_valid && (free_idx == IDX_W'(g))),
            .upd_i  (upd_valid && !q_full && (upd_idx == IDX_W'(g))),
            .delta_i(upd_delta),
            .post_o (post_v[g]),
            .ovf_o  (ovf_v[g])
        );
    end

    trig_fifo #(.DEPTH(Q_DEPTH), .DW(IDX_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (|post_v),
        .push_data_i(upd_idx),
        .pop_i      (trig_pop),
        .valid_o    (trig_valid),
        .head_o     (trig_idx),
        .full_o     (q_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |ovf_v;
    end

    always_comb begin
        upd_stall = q_full;
        err_ovf   = err_q;
    end
endmodule

// File: rtl/pend_ctr_chk.sv
module pend_ctr_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic             upd_stall,
    input logic             trig_valid,
    input logic [IDX_W-1:0] trig_idx,
    input logic             trig_pop,
    input logic             err_ovf
);
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && !trig_pop |=> trig_valid && $stable(trig_idx)); // R7
    AST_VALID_FALLS_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_valid) |-> $past(trig_pop)); // R7
    AST_STALL_HAS_ENTRIES: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stall |-> trig_valid); // R8
    AST_TRIG_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_valid) |-> $past(upd_valid)); // R4
    AST_OVF_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> $past(upd_valid) && !$past(upd_stall)); // R9
endmodule

bind pend_ctr_top pend_ctr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_stall (upd_stall),
    .trig_valid(trig_valid),
    .trig_idx  (trig_idx),
    .trig_pop  (trig_pop),
    .err_ovf   (err_ovf)
);

// File: tb/tb_pend_ctr_top.sv
module tb_pend_ctr_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int CW = 8;
    localparam int QD = 4;
    localparam int IW = 3;
    localparam int MAXV = 2 ** (CW - 1) - 1;
    localparam int MINV = -(2 ** (CW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0, free_valid = 1'b0, upd_valid = 1'b0, trig_pop = 1'b0;
    logic [IW-1:0] alloc_idx = '0, free_idx = '0, upd_idx = '0;
    logic [CW-1:0] upd_delta = '0;
    logic          upd_stall, trig_valid, err_ovf;
    logic [IW-1:0] trig_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_cnt [NT];
    int m_st  [NT];   // 0 idle, 1 waiting, 2 done
    int m_q   [$];
    bit m_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pend_ctr_top #(.N_TXN(NT), .CNT_W(CW), .Q_DEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .free_valid(free_valid), .free_idx(free_idx),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_delta(upd_delta),
        .upd_stall(upd_stall), .trig_valid(trig_valid), .trig_idx(trig_idx),
        .trig_pop(trig_pop), .err_ovf(err_ovf)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic idle_in();
        alloc_valid = 0; free_valid = 0; upd_valid = 0; trig_pop = 0;
    endtask

    // advance model by one edge with the inputs currently applied
    task automatic model_step();
        bit stall_now;
        bit push;
        int ui;
        int r;
        stall_now = (m_q.size() == QD);
        push = 0;
        m_err = 0;
        ui = int'(upd_idx);
        if (upd_valid && !stall_now && m_st[ui] != 0 &&
            !(alloc_valid && alloc_idx == upd_idx) && !(free_valid && free_idx == upd_idx)) begin
            r = m_cnt[ui] - int'($signed(upd_delta));
            m_err = (r != sat(r));
            r = sat(r);
            m_cnt[ui] = r;
            if (m_st[ui] == 1 && r == 0) begin
                m_st[ui] = 2;
                push = 1;
            end
        end
        if (alloc_valid) begin
            m_cnt[int'(alloc_idx)] = 0;
            m_st[int'(alloc_idx)] = 1;
        end else if (free_valid) begin
            m_st[int'(free_idx)] = 0;
        end
        if (alloc_valid && free_valid && free_idx != alloc_idx) m_st[int'(free_idx)] = 0;
        if (trig_pop && m_q.size() > 0) void'(m_q.pop_front());
        if (push) m_q.push_back(ui);
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        idle_in();
        chk(tag, "trig_valid", int'(trig_valid), int'(m_q.size() > 0));
        if (m_q.size() > 0) chk(tag, "trig_idx", int'(trig_idx), m_q[0]);
        chk(tag, "upd_stall", int'(upd_stall), int'(m_q.size() == QD));
        chk(tag, "err_ovf", int'(err_ovf), int'(m_err));
    endtask

    task automatic up(input int idx, input int d);
        upd_valid = 1; upd_idx = IW'(idx); upd_delta = CW'(d);
    endtask

    task automatic al(input int idx);
        alloc_valid = 1; alloc_idx = IW'(idx);
    endtask

    task automatic pop_all(input string tag);
        for (int k = 0; k < QD + 1; k++) begin
            trig_pop = 1;
            tick(tag);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        for (int i = 0; i < NT; i++) begin m_cnt[i] = 0; m_st[i] = 0; end
        m_err = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        chk("R1", "trig_valid", int'(trig_valid), 0);
        chk("R1", "upd_stall", int'(upd_stall), 0);
        chk("R1", "err_ovf", int'(err_ovf), 0);
        // unallocated slot: zero delta must not trigger
        up(5, 0); tick("R6");
        // R2/R4: fresh slot, delta 0 triggers
        al(0); tick("R2");
        up(0, 0); tick("R4");
        trig_pop = 1; tick("R7");
        // R10: out-of-order, negative transit
        al(1); tick("R2");
        up(1, 2); tick("R10");
        up(1, -1); tick("R10");
        up(1, -1); tick("R10");
        // R5: second zero crossing, no duplicate
        up(1, 1); tick("R5");
        up(1, -1); tick("R5");
        pop_all("R5");
        // R9: positive and negative saturation
        al(2); tick("R2");
        up(2, -128); tick("R9");
        up(2, 127); tick("R9");
        al(3); tick("R2");
        up(3, 127); tick("R9");
        up(3, 2); tick("R9");
        up(3, -128); tick("R9");
        pop_all("R9");
        // R6: allocate and update collide, then free and update collide
        al(6); up(6, 5); tick("R6");
        up(6, 0); tick("R6");
        al(7); tick("R2");
        free_valid = 1; free_idx = 3'd7; up(7, 0); tick("R6");
        up(7, 0); tick("R6");
        pop_all("R6");
        // R2: re-allocate a done slot clears it
        al(6); tick("R2");
        up(6, 0); tick("R2");
        pop_all("R2");
        // R8: fill queue, held-off update, then FIFO order
        for (int s = 0; s < 5; s++) begin al(s); tick("R8"); end
        for (int s = 3; s >= 0; s--) begin up(s, 0); tick("R8"); end
        up(4, 0); tick("R8");
        up(4, 0); trig_pop = 1; tick("R8");
        pop_all("R7");
        trig_pop = 1; tick("R7");
        // random phase: R3 counting with model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 5) == 0) al($urandom_range(0, NT - 1));
            if ($urandom_range(0, 7) == 0) begin
                free_valid = 1; free_idx = IW'($urandom_range(0, NT - 1));
            end
            if ($urandom_range(0, 1) == 0) begin
                if ($urandom_range(0, 49) == 0)
                    up($urandom_range(0, NT - 1), ($urandom_range(0, 1) == 0) ? MINV : MAXV);
                else
                    up($urandom_range(0, NT - 1), int'($urandom_range(0, 6)) - 3);
            end
            if ($urandom_range(0, 2) == 0) trig_pop = 1;
            tick("R3");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule